// File: doc/BRIEF.md
# Touch Sample Averaging Filter

This block converts a group of raw touch-panel samples into a single input event. When the sample FIFO signals its threshold, the filter reads up to four packed words from the FIFO. It mirrors both coordinate axes and looks at the pen flag of the last word. From that it produces either a touch report carrying an averaged position or a release event. After the consumer takes the event, the filter raises a one-cycle sync strobe.

If the FIFO overrun flag is set when a group starts, the filter empties the FIFO and produces no event. The FIFO shows its head word on `fifo_data_i` whenever `fifo_empty_i` is low, and a high `fifo_rd_o` at a clock edge removes that word. The event leaves on a valid/ready stream.

Top module: `touch_avg_filter`

## Requirements
- R1: After reset, `ev_valid_o`, `sync_o` and `fifo_rd_o` are low until a trigger arrives.
- R2: If `ovr_i` is high in the cycle a trigger is accepted, the filter pops words until the FIFO reports empty. It then returns to idle without raising `ev_valid_o` or `sync_o`.
- R3: In a normal group the filter pops words only while the FIFO is not empty. It stops after four pops or when the FIFO reports empty, whichever comes first. It never pops more than four words per group.
- R4: Word layout: X raw is bits 25:16, Y raw is bits 9:0, and bit 31 is the pen flag (0 = down, 1 = up). Each reported coordinate is computed from the mirrored value 0x3FF minus the raw field.
- R5: A report with `ev_touch_o`=1 is produced only when four words were popped and bit 31 of the fourth word is 0.
- R6: In a report, X and Y are each (m2 + m3) >> 1. Here m2 and m3 are the mirrored values of the second and third words. The sum is kept to 11 bits and the result rounds down, so outputs span 0 to 0x3FF.
- R7: In every other non-overrun case (fewer than four words, or the fourth word's pen is up), the event has `ev_touch_o`=0 and X = Y = 0.
- R8: `sync_o` is high for exactly one cycle, in the cycle right after each event handshake (`ev_valid_o` and `ev_ready_i` both high).
- R9: Triggers that arrive while a group is in progress are ignored: they cause no further pops and no second event.
- R10: While `ev_valid_o` is high and `ev_ready_i` is low, the event stays valid and X, Y and touch do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | FIFO threshold trigger, starts a group |
| ovr_i | input | 1 | FIFO overrun flag |
| fifo_empty_i | input | 1 | FIFO has no word available |
| fifo_data_i | input | 32 | FIFO head word |
| fifo_rd_o | output | 1 | Pop the head word at this edge |
| ev_ready_i | input | 1 | Consumer accepts the event |
| ev_valid_o | output | 1 | Event available |
| ev_x_o | output | 10 | Reported X coordinate |
| ev_y_o | output | 10 | Reported Y coordinate |
| ev_touch_o | output | 1 | 1 = touch report, 0 = release |
| sync_o | output | 1 | One-cycle strobe after each event |

## Verification
The bench checks the pen-up flag on the fourth word, since a filter that tested the first word would report a position instead of a release. It runs groups of three words and of zero words to catch a filter that reports after a short group or that waits for more data. It uses extreme raw values where the mirrored sum reaches 2046: a 10-bit adder would wrap, and rounding up would give a different result. It also covers overrun draining, a six-word FIFO where exactly two words must remain afterwards, and a retrigger during backpressure. A filter that drained only part of the FIFO, read past four words, or started a second group would leave the wrong FIFO fill or emit an extra event.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DRAIN   = 3'd1,
    ST_COLLECT = 3'd2,
    ST_EMIT    = 3'd3,
    ST_SYNC    = 3'd4
  } tsf_state_e;
endpackage

// File: rtl/tsf_ctrl.sv
module tsf_ctrl
  import tsf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic ovr_i,
  input  logic fifo_empty_i,
  input  logic group_full_i,
  input  logic ev_ready_i,
  output logic fifo_rd_o,
  output logic store_clr_o,
  output logic store_wr_o,
  output logic ev_load_o,
  output logic ev_valid_o,
  output logic sync_o
);
  tsf_state_e state_q, state_d;

  // next-state and output decode
  always_comb begin
    state_d     = state_q;
    fifo_rd_o   = 1'b0;
    store_clr_o = 1'b0;
    store_wr_o  = 1'b0;
    ev_load_o   = 1'b0;
    ev_valid_o  = 1'b0;
    sync_o      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (trig_i) begin
          store_clr_o = 1'b1;
          state_d     = ovr_i ? ST_DRAIN : ST_COLLECT;
        end
      end
      ST_DRAIN: begin
        if (!fifo_empty_i) fifo_rd_o = 1'b1;
        else               state_d   = ST_IDLE;
      end
      ST_COLLECT: begin
        if (group_full_i || fifo_empty_i) begin
          ev_load_o = 1'b1;
          state_d   = ST_EMIT;
        end else begin
          fifo_rd_o  = 1'b1;
          store_wr_o = 1'b1;
        end
      end
      ST_EMIT: begin
        ev_valid_o = 1'b1;
        if (ev_ready_i) state_d = ST_SYNC;
      end
      ST_SYNC: begin
        sync_o  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/tsf_slot_store.sv
module tsf_slot_store #(
  parameter int GROUP_N = 4,
  parameter int COORD_W = 10,
  localparam int CNT_W  = $clog2(GROUP_N + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clr_i,
  input  logic                             wr_i,
  input  logic [COORD_W-1:0]               x_i,
  input  logic [COORD_W-1:0]               y_i,
  input  logic                             pen_up_i,
  output logic [CNT_W-1:0]                 cnt_o,
  output logic                             full_o,
  output logic [GROUP_N-1:0][COORD_W-1:0]  xs_o,
  output logic [GROUP_N-1:0][COORD_W-1:0]  ys_o,
  output logic [GROUP_N-1:0]               pens_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign full_o = (cnt_q == CNT_W'(GROUP_N));
  assign cnt_o  = cnt_q;

  always_comb begin
    cnt_en = clr_i || (wr_i && !full_o);
    cnt_d  = clr_i ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  for (genvar s = 0; s < GROUP_N; s++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_i && (cnt_q == CNT_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        xs_o[s]   <= '0;
        ys_o[s]   <= '0;
        pens_o[s] <= 1'b1;
      end else if (slot_en) begin
        xs_o[s]   <= x_i;
        ys_o[s]   <= y_i;
        pens_o[s] <= pen_up_i;
      end
    end
  end
endmodule

// File: rtl/tsf_axis_avg.sv
module tsf_axis_avg #(
  parameter int COORD_W = 10,
  localparam int SUM_W  = COORD_W + 1
) (
  input  logic [COORD_W-1:0] raw_a_i,
  input  logic [COORD_W-1:0] raw_b_i,
  output logic [COORD_W-1:0] avg_o
);
  localparam logic [COORD_W-1:0] FULL_SCALE = {COORD_W{1'b1}};

  logic [COORD_W-1:0] mir_a, mir_b;
  logic [SUM_W-1:0]   sum;

  always_comb begin
    mir_a = FULL_SCALE - raw_a_i;
    mir_b = FULL_SCALE - raw_b_i;
    sum   = {1'b0, mir_a} + {1'b0, mir_b};
    avg_o = sum[SUM_W-1:1];
  end
endmodule

// File: rtl/touch_avg_filter.sv
module touch_avg_filter #(
  parameter int WORD_W  = 32,
  parameter int COORD_W = 10,
  parameter int GROUP_N = 4,
  parameter int X_LSB   = 16,
  parameter int Y_LSB   = 0,
  parameter int PEN_BIT = 31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_i,
  input  logic               ovr_i,
  input  logic               fifo_empty_i,
  input  logic [WORD_W-1:0]  fifo_data_i,
  output logic               fifo_rd_o,
  input  logic               ev_ready_i,
  output logic               ev_valid_o,
  output logic [COORD_W-1:0] ev_x_o,
  output logic [COORD_W-1:0] ev_y_o,
  output logic               ev_touch_o,
  output logic               sync_o
);
  localparam int CNT_W   = $clog2(GROUP_N + 1);
  localparam int AVG_LO  = 1;
  localparam int AVG_HI  = 2;
  localparam int N_AXES  = 2;

  logic store_clr, store_wr, ev_load, group_full;
  logic [CNT_W-1:0]                cnt;
  logic [GROUP_N-1:0][COORD_W-1:0] xs, ys;
  logic [GROUP_N-1:0]              pens;
  logic [N_AXES-1:0][COORD_W-1:0]  avg;

  tsf_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_i       (trig_i),
    .ovr_i        (ovr_i),
    .fifo_empty_i (fifo_empty_i),
    .group_full_i (group_full),
    .ev_ready_i   (ev_ready_i),
    .fifo_rd_o    (fifo_rd_o),
    .store_clr_o  (store_clr),
    .store_wr_o   (store_wr),
    .ev_load_o    (ev_load),
    .ev_valid_o   (ev_valid_o),
    .sync_o       (sync_o)
  );

  tsf_slot_store #(.GROUP_N(GROUP_N), .COORD_W(COORD_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (store_clr),
    .wr_i     (store_wr),
    .x_i      (fifo_data_i[X_LSB +: COORD_W]),
    .y_i      (fifo_data_i[Y_LSB +: COORD_W]),
    .pen_up_i (fifo_data_i[PEN_BIT]),
    .cnt_o    (cnt),
    .full_o   (group_full),
    .xs_o     (xs),
    .ys_o     (ys),
    .pens_o   (pens)
  );

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    logic [COORD_W-1:0] raw_lo, raw_hi;
    if (a == 0) begin : g_x
      assign raw_lo = xs[AVG_LO];
      assign raw_hi = xs[AVG_HI];
    end else begin : g_y
      assign raw_lo = ys[AVG_LO];
      assign raw_hi = ys[AVG_HI];
    end
    tsf_axis_avg #(.COORD_W(COORD_W)) u_avg (
      .raw_a_i (raw_lo),
      .raw_b_i (raw_hi),
      .avg_o   (avg[a])
    );
  end

  // event holding registers
  logic               report;
  logic [COORD_W-1:0] ev_x_d, ev_y_d;
  logic               ev_touch_d;

  always_comb begin
    report     = (cnt == CNT_W'(GROUP_N)) && !pens[GROUP_N-1];
    ev_touch_d = report;
    ev_x_d     = report ? avg[0] : '0;
    ev_y_d     = report ? avg[1] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_x_o     <= '0;
      ev_y_o     <= '0;
      ev_touch_o <= 1'b0;
    end else if (ev_load) begin
      ev_x_o     <= ev_x_d;
      ev_y_o     <= ev_y_d;
      ev_touch_o <= ev_touch_d;
    end
  end
endmodule

// File: rtl/tsf_checker.sv
module tsf_checker #(
  parameter int COORD_W = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fifo_empty_i,
  input logic               fifo_rd_o,
  input logic               ev_ready_i,
  input logic               ev_valid_o,
  input logic [COORD_W-1:0] ev_x_o,
  input logic [COORD_W-1:0] ev_y_o,
  input logic               ev_touch_o,
  input logic               sync_o
);
  p_pop_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_o |-> !fifo_empty_i);

  p_no_pop_while_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid_o |-> !fifo_rd_o);

  p_release_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid_o && !ev_touch_o) |-> (ev_x_o == '0 && ev_y_o == '0));

  p_sync_after_hs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> $past(ev_valid_o && ev_ready_i));

  p_hs_then_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid_o && ev_ready_i) |=> (sync_o && !ev_valid_o));

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid_o && !ev_ready_i) |=>
      (ev_valid_o && $stable(ev_x_o) && $stable(ev_y_o) && $stable(ev_touch_o)));
endmodule

bind touch_avg_filter tsf_checker #(.COORD_W(COORD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fifo_empty_i (fifo_empty_i),
  .fifo_rd_o    (fifo_rd_o),
  .ev_ready_i   (ev_ready_i),
  .ev_valid_o   (ev_valid_o),
  .ev_x_o       (ev_x_o),
  .ev_y_o       (ev_y_o),
  .ev_touch_o   (ev_touch_o),
  .sync_o       (sync_o)
);

// File: tb/touch_avg_filter_tb_top.sv
`timescale 1ns/1ps
module touch_avg_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic        ovr = 1'b0;
  logic        fifo_empty = 1'b1;
  logic [31:0] fifo_data = '0;
  logic        fifo_rd;
  logic        ev_ready = 1'b1;
  logic        ev_valid;
  logic [9:0]  ev_x, ev_y;
  logic        ev_touch;
  logic        sync;

  always #2 clk = ~clk;

  touch_avg_filter dut_i (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .ovr_i(ovr),
    .fifo_empty_i(fifo_empty), .fifo_data_i(fifo_data), .fifo_rd_o(fifo_rd),
    .ev_ready_i(ev_ready), .ev_valid_o(ev_valid), .ev_x_o(ev_x), .ev_y_o(ev_y),
    .ev_touch_o(ev_touch), .sync_o(sync)
  );

  int checks = 0;
  int fails  = 0;
  int pops   = 0;
  int ev_cnt = 0;
  int sync_cnt = 0;
  int cycles = 0;
  logic [9:0] last_x, last_y;
  logic       last_touch;
  logic       pop_due = 1'b0;
  logic [31:0] q[$];

  // monitor: sample away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (fifo_rd) begin pop_due = 1'b1; pops++; end
      if (ev_valid && ev_ready) begin
        ev_cnt++; last_x = ev_x; last_y = ev_y; last_touch = ev_touch;
      end
      if (sync) sync_cnt++;
    end
  end

  // FIFO model with show-ahead head word
  always @(posedge clk) begin
    #1;
    if (pop_due && q.size() > 0) void'(q.pop_front());
    pop_due = 1'b0;
    fifo_empty = (q.size() == 0);
    fifo_data  = (q.size() == 0) ? 32'h0 : q[0];
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit pen_up, input int xr, input int yr);
    return {pen_up, 5'b0, 10'(xr), 6'b0, 10'(yr)};
  endfunction

  function automatic int avg2(input int ra, input int rb);
    return ((1023 - ra) + (1023 - rb)) / 2;
  endfunction

  task automatic load(input logic [31:0] w[$]);
    @(negedge clk);
    foreach (w[i]) q.push_back(w[i]);
    repeat (2) @(posedge clk);
  endtask

  task automatic pulse_trig();
    @(posedge clk); #1; trig = 1'b1;
    @(posedge clk); #1; trig = 1'b0;
  endtask

  // wait for a handshake, then check the sync strobe one cycle later
  task automatic wait_event(input string req, output bit got);
    int start = ev_cnt;
    got = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      #0.1;
      if (ev_cnt != start) begin got = 1'b1; break; end
    end
    check(got, req, ev_cnt - start, 1);
    if (got) begin
      @(negedge clk);
      check(sync === 1'b1, "R8 sync after handshake", int'(sync), 1);
      @(negedge clk);
      check(sync === 1'b0, "R8 sync one cycle", int'(sync), 0);
    end
  endtask

  task automatic run_group(input string name, input logic [31:0] w[$],
                           input bit exp_touch, input int exp_x, input int exp_y,
                           input int exp_pops, input int exp_left);
    bit got;
    int p0 = pops;
    load(w);
    pulse_trig();
    wait_event({name, " event"}, got);
    repeat (4) @(negedge clk);
    check(last_touch == exp_touch, {name, " touch"}, int'(last_touch), int'(exp_touch));
    check(last_x == 10'(exp_x), {name, " x"}, int'(last_x), exp_x);
    check(last_y == 10'(exp_y), {name, " y"}, int'(last_y), exp_y);
    check(pops - p0 == exp_pops, {name, " pops"}, pops - p0, exp_pops);
    check(q.size() == exp_left, {name, " fifo left"}, q.size(), exp_left);
    q.delete();
    repeat (2) @(posedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(ev_valid === 1'b0, "R1 valid at reset", int'(ev_valid), 0);
    check(sync === 1'b0, "R1 sync at reset", int'(sync), 0);
    check(fifo_rd === 1'b0, "R1 rd at reset", int'(fifo_rd), 0);
  endtask

  task automatic t_report_basic();
    logic [31:0] w[$] = '{mk(0,100,10), mk(0,200,20), mk(0,300,31), mk(0,400,40)};
    run_group("R5 R4 R6 basic", w, 1'b1, avg2(200,300), avg2(20,31), 4, 0);
  endtask

  task automatic t_report_extremes();
    // mirrored sums reach 2046 (needs 11 bits) and odd sums round down
    logic [31:0] w[$] = '{mk(0,5,5), mk(0,0,0), mk(0,0,1023), mk(0,7,7)};
    run_group("R6 extremes", w, 1'b1, 1023, 511, 4, 0);
  endtask

  task automatic t_pen_up_last();
    logic [31:0] w[$] = '{mk(0,1,1), mk(0,2,2), mk(0,3,3), mk(1,4,4)};
    run_group("R5 R7 pen up on fourth", w, 1'b0, 0, 0, 4, 0);
  endtask

  task automatic t_pen_up_first();
    logic [31:0] w[$] = '{mk(1,1,1), mk(0,600,700), mk(0,602,701), mk(0,4,4)};
    run_group("R5 pen up on first only", w, 1'b1, avg2(600,602), avg2(700,701), 4, 0);
  endtask

  task automatic t_short();
    logic [31:0] w[$] = '{mk(0,10,10), mk(0,20,20), mk(0,30,30)};
    run_group("R3 R7 three words", w, 1'b0, 0, 0, 3, 0);
  endtask

  task automatic t_empty();
    logic [31:0] w[$];
    run_group("R3 R7 empty fifo", w, 1'b0, 0, 0, 0, 0);
  endtask

  task automatic t_overrun();
    logic [31:0] w[$] = '{mk(0,1,1), mk(0,2,2), mk(0,3,3)};
    int e0 = ev_cnt, s0 = sync_cnt, p0 = pops;
    load(w);
    @(posedge clk); #1; ovr = 1'b1; trig = 1'b1;
    @(posedge clk); #1; ovr = 1'b0; trig = 1'b0;
    repeat (30) @(negedge clk);
    check(q.size() == 0, "R2 drained", q.size(), 0);
    check(pops - p0 == 3, "R2 pops", pops - p0, 3);
    check(ev_cnt == e0, "R2 no event", ev_cnt - e0, 0);
    check(sync_cnt == s0, "R2 no sync", sync_cnt - s0, 0);
    check(ev_valid === 1'b0, "R2 valid low", int'(ev_valid), 0);
  endtask

  task automatic t_busy_backpressure();
    logic [31:0] w[$] = '{mk(0,50,60), mk(0,51,61), mk(0,53,63), mk(0,9,9),
                          mk(0,1,1), mk(0,2,2)};
    int e0, s0, p0;
    bit got;
    logic [9:0] hx;
    load(w);
    @(posedge clk); #1; ev_ready = 1'b0;
    e0 = ev_cnt; s0 = sync_cnt; p0 = pops;
    pulse_trig();
    repeat (10) @(negedge clk);
    hx = ev_x;
    check(ev_valid === 1'b1, "R10 valid held", int'(ev_valid), 1);
    check(sync_cnt == s0, "R8 no sync before accept", sync_cnt - s0, 0);
    pulse_trig();  // must be ignored (R9)
    repeat (5) @(negedge clk);
    check(ev_x == hx, "R10 x stable", int'(ev_x), int'(hx));
    check(pops - p0 == 4, "R3 R9 four pops only", pops - p0, 4);
    @(posedge clk); #1; ev_ready = 1'b1;
    wait_event("R10 accepted", got);
    repeat (30) @(negedge clk);
    check(ev_cnt - e0 == 1, "R9 single event", ev_cnt - e0, 1);
    check(q.size() == 2, "R3 R9 words left", q.size(), 2);
    check(last_x == 10'(avg2(51,53)), "R6 x after stall", int'(last_x), avg2(51,53));
    check(last_y == 10'(avg2(61,63)), "R6 y after stall", int'(last_y), avg2(61,63));
    q.delete();
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    t_reset();
    t_report_basic();
    t_report_extremes();
    t_pen_up_last();
    t_pen_up_first();
    t_short();
    t_empty();
    t_overrun();
    t_busy_backpressure();
    t_report_basic();
    repeat (5) @(posedge clk);
    summary();
    $finish;
  end
endmodule